// File: doc/BRIEF.md
# Sector ECC Syndrome Checker and Single-Bit Repair

This block judges one 512-byte flash sector against its 24-bit Hamming check code. The caller supplies two 24-bit words with a one-cycle start strobe. The first is the check code that was stored beside the sector. The second is the check code recomputed from the data as it came back. The block XORs the two words into a syndrome and classifies the sector as clean, repaired or beyond repair. A single flipped data bit is repaired in place: the block reads the affected byte from the sector buffer, inverts the bit and writes the byte back.

The sector buffer sits outside the block and is reached through a synchronous single-port RAM port. A read issued in one cycle returns its data in the next cycle, and that next cycle is also when the block issues the write. A result is announced by a one-cycle done pulse. The status code, byte address and bit index stay on their outputs until the next accepted start.

Top module: `nand_ecc_fixup`

## Requirements
- R1: Byte i of each 24-bit code occupies bits [8i+7:8i]. The syndrome bytes s0, s1 and s2 are the XOR of the matching stored and computed bytes.
- R2: After reset, busy, done, mem_en and mem_we are 0 and status is 2'b00.
- R3: An all-zero syndrome gives status 2'b00 (clean). The buffer is not accessed, and done pulses in the first cycle after the start edge.
- R4: If the stored code is 24'hFFFFFF, the status is 2'b00 whatever the syndrome is. The buffer is not accessed.
- R5: A syndrome in which bits 2k+1 and 2k differ for every k = 0..11 in all three bytes is a data-bit error. The status is 2'b01 (repaired).
- R6: For a data-bit error, err_addr[3:0] = s0 bits {7,5,3,1}, err_addr[7:4] = s1 bits {7,5,3,1} and err_addr[8] = s2 bit 1. In each group the higher address bit comes from the higher syndrome bit.
- R7: For a data-bit error, err_bit = {s2[7], s2[5], s2[3]}.
- R8: The repair is one read cycle at err_addr, then one write cycle at the same address with data equal to the read byte XOR (1 << err_bit). Done pulses in the cycle after the write, three cycles after the start edge. All other bytes are left unchanged.
- R9: A syndrome with exactly one bit set gives status 2'b01. The buffer is not accessed, and err_addr and err_bit read 0.
- R10: Any other syndrome gives status 2'b10 (uncorrectable). The buffer is not accessed, and err_addr and err_bit read 0.
- R11: Busy is high during the read and write cycles only. Done is a one-cycle pulse. A start that arrives while the block is not idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Evaluate the codes presented this cycle |
| ecc_stored | input | 24 | Check code read from the spare area |
| ecc_calc | input | 24 | Check code computed over the data read |
| busy | output | 1 | Buffer repair in progress |
| done | output | 1 | One-cycle result pulse |
| status | output | 2 | 00 clean, 01 repaired, 10 uncorrectable |
| err_addr | output | 9 | Byte address of the repaired bit |
| err_bit | output | 3 | Bit index within that byte |
| mem_en | output | 1 | Buffer access enable |
| mem_we | output | 1 | Buffer write enable |
| mem_addr | output | 9 | Buffer address |
| mem_wdata | output | 8 | Buffer write data |
| mem_rdata | input | 8 | Buffer read data, valid one cycle after a read |

## Verification
A wrong latched address or bit index shows up in the buffer model within three cycles of start: one byte is corrupted and the intended byte is left unrepaired. A state register that lingers or skips a step shows up in the cycle count to done or in the number of read and write cycles the bench observes. A misclassification appears on status at the first done pulse. Each scenario also checks the boundary codes that sit next to a wrong branch: a fixable-looking syndrome behind an erased code, the top and bottom single syndrome bits, and the first and last byte addresses.

// File: rtl/nand_ecc_fixup.sv
module nand_ecc_fixup (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [23:0] ecc_stored,
  input  logic [23:0] ecc_calc,
  output logic       busy,
  output logic       done,
  output logic [1:0] status,
  output logic [8:0] err_addr,
  output logic [2:0] err_bit,
  output logic       mem_en,
  output logic       mem_we,
  output logic [8:0] mem_addr,
  output logic [7:0] mem_wdata,
  input  logic [7:0] mem_rdata
);
  localparam logic [1:0] ST_CLEAN = 2'b00;
  localparam logic [1:0] ST_FIXED = 2'b01;
  localparam logic [1:0] ST_BAD   = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_FIN} state_t;
  state_t state;

  function automatic logic pairs_split(input logic [7:0] d);
    return ((d ^ (d >> 1)) & 8'h55) == 8'h55;
  endfunction

  // R1 syndrome bytes
  logic [23:0] syn;
  logic [7:0]  s0, s1, s2;
  assign syn = ecc_stored ^ ecc_calc;
  assign s0 = syn[7:0];
  assign s1 = syn[15:8];
  assign s2 = syn[23:16];

  logic quiet, data_err, code_err, need_fix;
  assign quiet    = (syn == 24'd0) || (&ecc_stored);
  assign data_err = pairs_split(s0) && pairs_split(s1) && pairs_split(s2);
  assign code_err = (syn & (syn - 24'd1)) == 24'd0;
  assign need_fix = !quiet && data_err;

  logic [1:0] cls;
  assign cls = quiet ? ST_CLEAN : (data_err || code_err) ? ST_FIXED : ST_BAD;

  logic [8:0] dec_addr;
  logic [2:0] dec_bit;
  assign dec_addr = {s2[1], s1[7], s1[5], s1[3], s1[1], s0[7], s0[5], s0[3], s0[1]};
  assign dec_bit  = {s2[7], s2[5], s2[3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      status   <= ST_CLEAN;
      err_addr <= '0;
      err_bit  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          status   <= cls;
          err_addr <= need_fix ? dec_addr : 9'd0;
          err_bit  <= need_fix ? dec_bit : 3'd0;
          state    <= need_fix ? S_RD : S_FIN;
        end
        S_RD:    state <= S_WR;
        S_WR:    state <= S_FIN;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state == S_RD) || (state == S_WR);
  assign done      = state == S_FIN;
  assign mem_en    = busy;
  assign mem_we    = state == S_WR;
  assign mem_addr  = err_addr;
  assign mem_wdata = mem_rdata ^ (8'd1 << err_bit);

  a_r8_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_en && !mem_we) && $stable(mem_addr));
  a_r8_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> done && status == ST_FIXED);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(err_addr) && $stable(err_bit) && $stable(status));
  a_r10_legal_status: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> status != 2'b11);
  a_r9_no_location: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == ST_BAD) |-> err_addr == 9'd0 && err_bit == 3'd0);
endmodule

// File: tb/nand_ecc_fixup_tb_top.sv
`timescale 1ns/1ps
module nand_ecc_fixup_tb_top;
  logic clk = 0, rst_n = 0, start = 0;
  logic [23:0] ecc_stored = '0, ecc_calc = '0;
  logic busy, done, mem_en, mem_we;
  logic [1:0] status;
  logic [8:0] err_addr, mem_addr;
  logic [2:0] err_bit;
  logic [7:0] mem_wdata, mem_rdata;
  int checks = 0, fails = 0, nrd = 0, nwr = 0, cyc = 0;
  bit finished = 0;
  logic [7:0] ram [512];
  logic [7:0] exp_ram [512];

  always #4 clk = ~clk;

  nand_ecc_fixup dut_i (.clk(clk), .rst_n(rst_n), .start(start), .ecc_stored(ecc_stored),
    .ecc_calc(ecc_calc), .busy(busy), .done(done), .status(status), .err_addr(err_addr),
    .err_bit(err_bit), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always @(posedge clk) if (mem_en) begin
    if (mem_we) begin ram[mem_addr] <= mem_wdata; nwr++; end
    else begin mem_rdata <= ram[mem_addr]; nrd++; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  function automatic logic [23:0] mk_syn(input logic [8:0] a, input logic [2:0] b);
    logic [23:0] s = '0;
    for (int k = 0; k < 4; k++) begin
      s[2*k+1] = a[k];   s[2*k] = ~a[k];
      s[8+2*k+1] = a[4+k]; s[8+2*k] = ~a[4+k];
    end
    s[17] = a[8]; s[16] = ~a[8];
    s[19] = b[0]; s[18] = ~b[0];
    s[21] = b[1]; s[20] = ~b[1];
    s[23] = b[2]; s[22] = ~b[2];
    return s;
  endfunction

  task automatic fill();
    for (int i = 0; i < 512; i++) begin ram[i] = 8'(i * 7 + 3) ^ {7'd0, i[8]}; exp_ram[i] = ram[i]; end
  endtask

  function automatic int ram_diffs();
    int n = 0;
    for (int i = 0; i < 512; i++) if (ram[i] !== exp_ram[i]) n++;
    return n;
  endfunction

  task automatic run(input logic [23:0] st, input logic [23:0] ca);
    @(negedge clk);
    nrd = 0; nwr = 0;
    ecc_stored = st; ecc_calc = ca; start = 1;
    @(negedge clk); start = 0; cyc = 1;
    while (!done && cyc < 40) begin @(negedge clk); cyc++; end
    if (!done) chk(0, "watchdog", cyc, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !mem_en && !mem_we, "R2 idle outputs", {busy, done, mem_en, mem_we}, 0);
    chk(status == 2'b00, "R2 status", status, 0);
  endtask

  task automatic t_clean(input logic [23:0] code);
    fill(); run(code, code);
    chk(status == 2'b00, "R3 clean status", status, 0);
    chk(cyc == 1, "R3 latency", cyc, 1);
    chk(nrd + nwr == 0 && ram_diffs() == 0, "R3 no access", nrd + nwr, 0);
  endtask

  task automatic t_erased(input logic [23:0] ca);
    fill(); run(24'hFFFFFF, ca);
    chk(status == 2'b00, "R4 erased status", status, 0);
    chk(nrd + nwr == 0 && ram_diffs() == 0, "R4 no access", nrd + nwr, 0);
  endtask

  task automatic t_fix(input logic [8:0] a, input logic [2:0] b, input logic [23:0] base);
    fill(); exp_ram[a] = exp_ram[a] ^ (8'd1 << b);
    run(base, base ^ mk_syn(a, b));
    chk(status == 2'b01, "R5 repaired status", status, 1);
    chk(err_addr == a, "R6 byte address", err_addr, a);
    chk(err_bit == b, "R7 bit index", err_bit, b);
    chk(cyc == 3, "R8 latency", cyc, 3);
    chk(nrd == 1 && nwr == 1, "R8 one read one write", nrd * 16 + nwr, 17);
    chk(ram_diffs() == 0, "R8 buffer content", ram_diffs(), 0);
  endtask

  task automatic t_code_bit(input int pos);
    fill(); run(24'h0A0B0C, 24'h0A0B0C ^ (24'd1 << pos));
    chk(status == 2'b01, "R9 code-bit status", status, 1);
    chk(err_addr == 0 && err_bit == 0, "R9 fields zero", {err_addr, err_bit}, 0);
    chk(nrd + nwr == 0 && ram_diffs() == 0, "R9 no access", nrd + nwr, 0);
  endtask

  task automatic t_bad(input logic [23:0] syn);
    fill(); run(24'h123456, 24'h123456 ^ syn);
    chk(status == 2'b10, "R10 uncorrectable", status, 2);
    chk(err_addr == 0 && err_bit == 0, "R10 fields zero", {err_addr, err_bit}, 0);
    chk(nrd + nwr == 0 && ram_diffs() == 0, "R10 no access", nrd + nwr, 0);
  endtask

  task automatic t_busy_ignore();
    fill(); exp_ram[10] = exp_ram[10] ^ 8'h02;
    @(negedge clk); nrd = 0; nwr = 0;
    ecc_stored = 0; ecc_calc = mk_syn(9'd10, 3'd1); start = 1;
    @(negedge clk);
    chk(busy, "R11 busy in read", busy, 1);
    ecc_calc = mk_syn(9'd20, 3'd4);
    @(negedge clk);
    chk(busy, "R11 busy in write", busy, 1);
    @(negedge clk);
    start = 0;
    chk(done && !busy, "R11 done after write", {done, busy}, 2);
    chk(err_addr == 10 && err_bit == 1, "R11 second start ignored", err_addr, 10);
    @(negedge clk);
    chk(!done, "R11 done one cycle", done, 0);
    chk(nrd == 1 && nwr == 1 && ram_diffs() == 0, "R11 single repair", nrd * 16 + nwr, 17);
  endtask

  initial begin
    fill();
    #20 rst_n = 1;
    @(negedge clk); t_reset();
    t_clean(24'h000000); t_clean(24'h5A3C96);
    t_erased(24'h123456); t_erased(24'hFFFFFF ^ mk_syn(9'd5, 3'd3));
    t_fix(9'd0, 3'd0, 24'h000000); t_fix(9'd511, 3'd7, 24'h00FF00);
    t_fix(9'h155, 3'd2, 24'hC3A512); t_fix(9'h0AA, 3'd5, 24'h000001);
    t_code_bit(0); t_code_bit(8); t_code_bit(23);
    t_bad(24'h000003); t_bad(mk_syn(9'd7, 3'd1) ^ 24'h010000); t_bad(24'hFFFFFF);
    t_busy_ignore();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule